// File: doc/BRIEF.md
# Shared-ALU Byte Datapath with Nibble-Serial Arithmetic

This block is the arithmetic core of a small 8-bit processor. Eight byte-wide storage slots sit in one register memory: accumulator, two index registers, stack pointer, the two program-counter bytes, a status byte and an operand latch that holds the last byte taken from the bus. Two read ports feed a 4-bit adder/subtractor. A byte-wide shift/rotate unit sits beside the adder and takes the same inputs. Every operation sends its operand through this shared unit and writes exactly one slot. This holds even when the operand is passed through unchanged.

The adder is half the width of the data. Each byte operation uses two internal clocks: the low nibble in the first, the high nibble in the second. The nibble carry is held in a flop between the two. There is no separate program-counter incrementer. On request, the low PC byte goes through the adder with a forced carry-in, and then the high byte goes through with the carry that came out of the low byte.

Instruction decode, bus timing and memory are outside the block. A test control interface drives operations, increment requests, direct operand-latch loads and a registered readback port.

Top module: `sad_datapath`

## Requirements
- R1: After synchronous reset, all eight slots read 0x00, the four flags are 0, `busy` is 0 and `result` is 0x00.
- R2: With `busy` low and neither `pc_inc` nor `start` asserted, `load_operand` writes `din` into slot 7 (operand latch) at the next clock. The flags stay unchanged. A `load_operand` pulse while `busy` is high has no effect.
- R3: A `start` taken while `busy` is low raises `busy` for exactly one clock. At the following clock the byte result, flags and destination slot update together and `busy` returns low. `start` while `busy` is high is ignored. `pc_inc` has priority over `start`, which has priority over `load_operand`.
- R4: Operation code 3'b001 computes port A + port B + C. C becomes the carry out of bit 7, and V is set when both operands share a sign bit that differs from the result's sign bit.
- R5: Operation code 3'b010 computes port A + ~port B + C. C is the carry out (1 means no borrow), and V follows the same rule as R4 with ~B as the second operand.
- R6: Code 3'b011 shifts port A left and code 3'b100 shifts it right. Each inserts 0 at the vacated end and copies the bit shifted out (bit 7 for left, bit 0 for right) into C.
- R7: Code 3'b101 rotates port A left and code 3'b110 rotates it right, both through the carry. The old C enters at the vacated end and the bit shifted out becomes the new C.
- R8: Code 3'b000 passes port A and code 3'b111 passes port B unchanged. Both leave C and V unchanged.
- R9: Every operation of R4–R8 sets Z when the written byte is 0x00 and sets N to bit 7 of that byte.
- R10: An operation writes only its destination slot. The other seven slots keep their values.
- R11: `pc_inc` increments the 16-bit value {slot 5 (PC high), slot 4 (PC low)} by one. The low byte is written after the second clock and the high byte after the fourth. `busy` is high for the three clocks in between. No flag changes.
- R12: `rd_data` shows the contents of slot `rd_sel` one clock after `rd_sel` is applied. Slot numbering: 0 A, 1 X, 2 Y, 3 SP, 4 PC low, 5 PC high, 6 status, 7 operand latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when not busy |
| op_sel | input | 3 | Operation code (R4–R8) |
| src_a | input | 3 | Slot on read port A |
| src_b | input | 3 | Slot on read port B |
| dst | input | 3 | Destination slot |
| pc_inc | input | 1 | Request a program-counter increment |
| load_operand | input | 1 | Load `din` into the operand latch |
| din | input | 8 | Byte injected as bus data |
| rd_sel | input | 3 | Readback slot select |
| rd_data | output | 8 | Registered readback data |
| result | output | 8 | Last byte written by an operation |
| busy | output | 1 | Operation or increment in progress |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench targets the carry that crosses between nibbles. Sums such as 0x7F+0x01 and 0xFF+0x01+C expose a design that drops the held nibble carry, because their high nibble would come out one short. The two PC wraps, 0x00FF to 0x0100 and 0xFFFF to 0x0000, expose a high-byte step that ignores or always applies the low-byte carry. A mistake there leaves PC high stale or bumps it on every increment. All sixteen combinations of shift/rotate kind, incoming carry and edge bit are tried, which catches an inverted insert bit or a carry taken from the wrong end. A `start` and a `load_operand` issued while busy must leave every slot untouched, which catches a design that accepts work mid-operation.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int DATA_W = 8;
  localparam int NUM_REGS = 8;

  localparam int REG_A   = 0;
  localparam int REG_PCL = 4;
  localparam int REG_PCH = 5;
  localparam int REG_OPR = 7;

  typedef enum logic [2:0] {
    OP_PASSA = 3'b000,
    OP_ADC   = 3'b001,
    OP_SBC   = 3'b010,
    OP_SHL   = 3'b011,
    OP_SHR   = 3'b100,
    OP_ROL   = 3'b101,
    OP_ROR   = 3'b110,
    OP_PASSB = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI,
    ST_PCL_HI,
    ST_PCH_LO,
    ST_PCH_HI
  } state_e;
endpackage

// File: rtl/sad_regfile.sv
module sad_regfile #(
  parameter int W = 8,
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b,
  input  logic [AW-1:0] raddr_c,
  output logic [W-1:0]  rdata_c
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
  assign rdata_c = mem[raddr_c];
endmodule

// File: rtl/sad_nib_adder.sv
module sad_nib_adder #(
  parameter int NW = 4
) (
  input  logic [NW-1:0] a,
  input  logic [NW-1:0] b,
  input  logic          ci,
  output logic [NW-1:0] s,
  output logic          co
);
  always_comb begin
    logic c;
    c = ci;
    for (int i = 0; i < NW; i++) begin
      s[i] = a[i] ^ b[i] ^ c;
      c    = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    co = c;
  end

  // R4: ripple chain agrees with integer addition
  always_comb begin
    if (!$isunknown({a, b, ci})) begin
      assert_nibble_sum_R4: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{NW{1'b0}}, ci}))
        else $error("nibble adder sum mismatch");
    end
  end
endmodule

// File: rtl/sad_shifter.sv
module sad_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0]  din,
  input  sad_pkg::op_e  op,
  input  logic          cin,
  output logic [W-1:0]  dout,
  output logic          cout
);
  import sad_pkg::*;

  always_comb begin
    unique case (op)
      OP_SHL: begin dout = {din[W-2:0], 1'b0}; cout = din[W-1]; end
      OP_SHR: begin dout = {1'b0, din[W-1:1]}; cout = din[0];   end
      OP_ROL: begin dout = {din[W-2:0], cin};  cout = din[W-1]; end
      OP_ROR: begin dout = {cin, din[W-1:1]};  cout = din[0];   end
      default: begin dout = din; cout = cin; end
    endcase
  end
endmodule

// File: rtl/sad_datapath.sv
module sad_datapath #(
  parameter int W = sad_pkg::DATA_W,
  parameter int NREG = sad_pkg::NUM_REGS,
  localparam int AW = $clog2(NREG),
  localparam int HW = W / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op_sel,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic [AW-1:0] dst,
  input  logic          pc_inc,
  input  logic          load_operand,
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] rd_sel,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  result,
  output logic          busy,
  output logic          flag_c,
  output logic          flag_z,
  output logic          flag_n,
  output logic          flag_v
);
  import sad_pkg::*;

  state_e state;

  logic [AW-1:0] rf_ra, rf_rb, rf_waddr;
  logic [W-1:0]  rf_rda, rf_rdb, rf_rdc, rf_wdata;
  logic          rf_we;

  logic [W-1:0]  a_q, b_q;
  logic [HW-1:0] lo_q;
  logic          nib_c_q, pc_c_q;
  op_e           op_q;
  logic [AW-1:0] dst_q;

  logic          lo_phase, pc_mode, do_load;
  op_e           cur_op;
  logic [W-1:0]  opa, opb, bx, sh_out, full;
  logic [HW-1:0] add_a, add_b, add_s, nib_out;
  logic          add_ci, add_co, sh_c;

  assign busy     = (state != ST_IDLE);
  assign lo_phase = (state == ST_IDLE) || (state == ST_PCH_LO);
  assign pc_mode  = (state == ST_IDLE) ? pc_inc : (state != ST_HI);
  assign do_load  = (state == ST_IDLE) && !pc_inc && !start && load_operand;

  // Read address steering: the increment sequence borrows port A.
  always_comb begin
    if (state == ST_PCH_LO)                 rf_ra = AW'(REG_PCH);
    else if (state == ST_IDLE && pc_inc)    rf_ra = AW'(REG_PCL);
    else                                    rf_ra = src_a;
  end
  assign rf_rb = src_b;

  sad_regfile #(.W(W), .N(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr_a(rf_ra), .rdata_a(rf_rda),
    .raddr_b(rf_rb), .rdata_b(rf_rdb),
    .raddr_c(rd_sel), .rdata_c(rf_rdc)
  );

  // Operand selection: live ports in the low half, held bytes in the high half.
  assign cur_op = pc_mode ? OP_ADC : (lo_phase ? op_e'(op_sel) : op_q);
  assign opa    = lo_phase ? rf_rda : a_q;
  assign opb    = pc_mode ? '0 : (lo_phase ? rf_rdb : b_q);
  assign bx     = (cur_op == OP_SBC) ? ~opb : opb;

  always_comb begin
    if (!lo_phase)                    add_ci = nib_c_q;
    else if (state == ST_PCH_LO)      add_ci = pc_c_q;
    else if (pc_mode)                 add_ci = 1'b1;
    else                              add_ci = flag_c;
  end

  assign add_a = lo_phase ? opa[HW-1:0] : opa[W-1:HW];
  assign add_b = lo_phase ? bx[HW-1:0]  : bx[W-1:HW];

  sad_nib_adder #(.NW(HW)) u_add (
    .a(add_a), .b(add_b), .ci(add_ci), .s(add_s), .co(add_co)
  );

  sad_shifter #(.W(W)) u_shf (
    .din(opa), .op(cur_op), .cin(flag_c), .dout(sh_out), .cout(sh_c)
  );

  always_comb begin
    unique case (cur_op)
      OP_PASSA:        nib_out = lo_phase ? opa[HW-1:0] : opa[W-1:HW];
      OP_PASSB:        nib_out = lo_phase ? opb[HW-1:0] : opb[W-1:HW];
      OP_ADC, OP_SBC:  nib_out = add_s;
      default:         nib_out = lo_phase ? sh_out[HW-1:0] : sh_out[W-1:HW];
    endcase
  end

  assign full = {nib_out, lo_q};

  // Single write port: one destination per clock.
  always_comb begin
    rf_we    = 1'b1;
    rf_wdata = full;
    unique case (state)
      ST_HI:     rf_waddr = dst_q;
      ST_PCL_HI: rf_waddr = AW'(REG_PCL);
      ST_PCH_HI: rf_waddr = AW'(REG_PCH);
      default: begin
        rf_we    = do_load;
        rf_waddr = AW'(REG_OPR);
        rf_wdata = din;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      lo_q    <= '0;
      nib_c_q <= 1'b0;
      pc_c_q  <= 1'b0;
      op_q    <= OP_PASSA;
      dst_q   <= '0;
      result  <= '0;
      flag_c  <= 1'b0;
      flag_z  <= 1'b0;
      flag_n  <= 1'b0;
      flag_v  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_data <= rf_rdc;
      unique case (state)
        ST_IDLE: begin
          if (pc_inc)     state <= ST_PCL_HI;
          else if (start) state <= ST_HI;
        end
        ST_HI:     state <= ST_IDLE;
        ST_PCL_HI: state <= ST_PCH_LO;
        ST_PCH_LO: state <= ST_PCH_HI;
        default:   state <= ST_IDLE;
      endcase
      if (lo_phase) begin
        a_q     <= opa;
        b_q     <= opb;
        lo_q    <= nib_out;
        nib_c_q <= add_co;
        op_q    <= cur_op;
        dst_q   <= dst;
      end
      if (state == ST_PCL_HI) pc_c_q <= add_co;
      if (state == ST_HI) begin
        result <= full;
        flag_z <= (full == '0);
        flag_n <= full[W-1];
        unique case (op_q)
          OP_ADC, OP_SBC: begin
            flag_c <= add_co;
            flag_v <= (a_q[W-1] == bx[W-1]) && (full[W-1] != a_q[W-1]);
          end
          OP_SHL, OP_SHR, OP_ROL, OP_ROR: flag_c <= sh_c;
          default: ;
        endcase
      end
    end
  end

  // R3: an accepted operation is busy for exactly one clock
  assert_one_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && !pc_inc) |=> busy ##1 !busy)
    else $error("operation busy window wrong");

  // R3: flags move only on the writing clock of an operation
  assert_flags_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable({flag_c, flag_z, flag_n, flag_v}))
    else $error("flags changed while idle");

  // R2: the only write possible while idle targets the operand latch
  assert_idle_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && rf_we) |-> (rf_waddr == AW'(REG_OPR)))
    else $error("idle write to wrong slot");

  // R11: increment steps keep flags and end with a PC-high write
  assert_pc_flags_R11: assert property (@(posedge clk) disable iff (rst)
    (state inside {ST_PCL_HI, ST_PCH_LO, ST_PCH_HI}) |=> $stable({flag_c, flag_z, flag_n, flag_v}))
    else $error("flags changed during PC increment");

  assert_pc_seq_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PCL_HI) |=> (state == ST_PCH_LO) ##1 (rf_we && rf_waddr == AW'(REG_PCH)))
    else $error("PC high step missing");
endmodule

// File: tb/test_sad_datapath.sv
`timescale 1ns/1ps
module test_sad_datapath;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] op_sel = '0, src_a = '0, src_b = '0, dst = '0, rd_sel = '0;
  logic       pc_inc = 1'b0, load_operand = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] rd_data, result;
  logic       busy, flag_c, flag_z, flag_n, flag_v;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] rm [8];
  logic       mc, mz, mn, mv;

  always #2.5 clk = ~clk;

  sad_datapath i_sad_datapath (
    .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .src_a(src_a),
    .src_b(src_b), .dst(dst), .pc_inc(pc_inc), .load_operand(load_operand),
    .din(din), .rd_sel(rd_sel), .rd_data(rd_data), .result(result),
    .busy(busy), .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
  );

  // stimulus vectors {op, src_a, src_b, dst}
  localparam logic [11:0] VEC [12] = '{
    {3'b001, 3'd0, 3'd1, 3'd0},  // 7F+01 -> 80, V
    {3'b011, 3'd2, 3'd2, 3'd2},  // 80<<1 -> 00, C
    {3'b001, 3'd3, 3'd1, 3'd3},  // FF+01+C
    {3'b010, 3'd1, 3'd1, 3'd1},  // 01-01 with C
    {3'b110, 3'd6, 3'd6, 3'd6},  // ror status slot
    {3'b101, 3'd0, 3'd0, 3'd0},  // rol A
    {3'b101, 3'd3, 3'd3, 3'd1},  // rol SP -> X
    {3'b100, 3'd6, 3'd6, 3'd2},  // shr status -> Y
    {3'b010, 3'd0, 3'd3, 3'd0},  // A - SP
    {3'b111, 3'd0, 3'd6, 3'd3},  // pass B
    {3'b010, 3'd2, 3'd6, 3'd2},  // Y - status
    {3'b001, 3'd6, 3'd6, 3'd6}   // status + status
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic read_slot(input int idx, input string req);
    @(negedge clk); rd_sel = 3'(idx);
    @(negedge clk);
    chk(rd_data === rm[idx], req, {8'h0, rd_data}, {8'h0, rm[idx]});
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 8; i++) read_slot(i, req);
  endtask

  task automatic run_op(input logic [2:0] op, input logic [2:0] sa, input logic [2:0] sb,
                        input logic [2:0] d, input string req);
    logic [7:0] a, b, r;
    logic [8:0] s;
    logic c, v;
    a = rm[sa]; b = rm[sb]; c = mc; v = mv; r = a;
    case (op)
      3'b000: r = a;
      3'b111: r = b;
      3'b001: begin s = {1'b0,a} + {1'b0,b} + {8'h0,mc}; r = s[7:0]; c = s[8];
                    v = (a[7]==b[7]) && (r[7]!=a[7]); end
      3'b010: begin s = {1'b0,a} + {1'b0,~b} + {8'h0,mc}; r = s[7:0]; c = s[8];
                    v = (a[7]==~b[7]) && (r[7]!=a[7]); end
      3'b011: begin r = {a[6:0],1'b0}; c = a[7]; end
      3'b100: begin r = {1'b0,a[7:1]}; c = a[0]; end
      3'b101: begin r = {a[6:0],mc}; c = a[7]; end
      default: begin r = {mc,a[7:1]}; c = a[0]; end
    endcase
    @(negedge clk);
    start = 1; op_sel = op; src_a = sa; src_b = sb; dst = d;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R3 busy mid-op", {15'h0, busy}, 16'h1);
    @(negedge clk);
    chk(busy === 1'b0, "R3 busy end", {15'h0, busy}, 16'h0);
    chk(result === r, req, {8'h0, result}, {8'h0, r});
    chk({flag_c,flag_z,flag_n,flag_v} === {c, r==8'h0, r[7], v}, "R9 flags",
        {12'h0, flag_c,flag_z,flag_n,flag_v}, {12'h0, c, r==8'h0, r[7], v});
    mc = c; mz = (r == 8'h0); mn = r[7]; mv = v;
    rm[d] = r;
    read_slot(d, req);
  endtask

  task automatic load_opr(input logic [7:0] v);
    @(negedge clk); load_operand = 1; din = v;
    @(negedge clk); load_operand = 0;
    rm[7] = v;
  endtask

  task automatic put(input int idx, input logic [7:0] v);
    load_opr(v);
    run_op(3'b000, 3'd7, 3'd7, 3'(idx), "R8 pass A");
  endtask

  task automatic pc_step(input logic [7:0] lo, input logic [7:0] hi);
    logic [15:0] nxt;
    logic [3:0] fl;
    put(4, lo); put(5, hi);
    fl = {flag_c, flag_z, flag_n, flag_v};
    nxt = {hi, lo} + 16'h1;
    @(negedge clk); pc_inc = 1;
    @(negedge clk); pc_inc = 0;
    chk(busy === 1'b1, "R11 busy clk1", {15'h0, busy}, 16'h1);
    @(negedge clk); chk(busy === 1'b1, "R11 busy clk2", {15'h0, busy}, 16'h1);
    @(negedge clk); chk(busy === 1'b1, "R11 busy clk3", {15'h0, busy}, 16'h1);
    @(negedge clk); chk(busy === 1'b0, "R11 busy end", {15'h0, busy}, 16'h0);
    chk({flag_c,flag_z,flag_n,flag_v} === fl, "R11 flags kept", {12'h0,flag_c,flag_z,flag_n,flag_v}, {12'h0, fl});
    rm[4] = nxt[7:0]; rm[5] = nxt[15:8];
    read_slot(4, "R11 PC low");
    read_slot(5, "R11 PC high");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R3 watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) rm[i] = 8'h00;
    mc = 0; mz = 0; mn = 0; mv = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1 busy", {15'h0, busy}, 16'h0);
    chk(result === 8'h00, "R1 result", {8'h0, result}, 16'h0);
    chk({flag_c,flag_z,flag_n,flag_v} === 4'h0, "R1 flags", {12'h0,flag_c,flag_z,flag_n,flag_v}, 16'h0);
    check_all("R1 slots");

    // R2 direct load, flags unchanged
    load_opr(8'hA5);
    chk({flag_c,flag_z,flag_n,flag_v} === 4'h0, "R2 flags kept", {12'h0,flag_c,flag_z,flag_n,flag_v}, 16'h0);
    read_slot(7, "R2 latch");

    // vector table walk
    put(0, 8'h7F); put(1, 8'h01); put(2, 8'h80); put(3, 8'hFF); put(6, 8'h3C);
    for (int k = 0; k < 12; k++) begin
      string req;
      case (VEC[k][11:9])
        3'b001: req = "R4 add";
        3'b010: req = "R5 sub";
        3'b011, 3'b100: req = "R6 shift";
        3'b101, 3'b110: req = "R7 rotate";
        default: req = "R8 pass";
      endcase
      run_op(VEC[k][11:9], VEC[k][8:6], VEC[k][5:3], VEC[k][2:0], req);
    end
    check_all("R10 other slots");

    // R6/R7 every shift kind x carry-in x edge bit
    for (int oi = 0; oi < 4; oi++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int bo = 0; bo < 2; bo++) begin
          put(0, (bo != 0) ? 8'hC3 : 8'h3C);
          load_opr((ci != 0) ? 8'h80 : 8'h00);
          run_op(3'b011, 3'd7, 3'd7, 3'd3, "R6 carry setup");
          run_op(3'(3 + oi), 3'd0, 3'd0, 3'd2, (oi < 2) ? "R6 shift case" : "R7 rotate case");
        end
      end
    end

    // R3/R2: start and load while busy are ignored
    put(1, 8'h11);
    @(negedge clk);
    start = 1; op_sel = 3'b001; src_a = 3'd1; src_b = 3'd1; dst = 3'd1;
    @(negedge clk);
    op_sel = 3'b111; src_b = 3'd7; dst = 3'd6; load_operand = 1; din = 8'h5A;
    @(negedge clk);
    start = 0; load_operand = 0;
    begin
      logic [8:0] s;
      s = 9'h022 + {8'h0, mc};
      chk(result === s[7:0], "R3 first op result", {8'h0, result}, {7'h0, s});
      rm[1] = s[7:0]; mc = s[8]; mz = (s[7:0] == 0); mn = s[7]; mv = 1'b0;
    end
    check_all("R3 ignored while busy");

    // R12 readback latency covered above; R11 PC increments
    pc_step(8'hFF, 8'h00);
    pc_step(8'hFF, 8'hFF);
    pc_step(8'h34, 8'h12);
    check_all("R10 after PC");

    done = 1;
    summary();
    $finish;
  end
endmodule